// File: doc/BRIEF.md
# I2C Synchronizing SCL Generator

This block generates the serial clock for one master on a shared open-drain SCL wire. It pulls the line low for a programmable number of system clock cycles, releases it, and after a programmable high time pulls it low again. Because the wire is a wired-AND, other masters can hold it low longer or pull it low early. The block follows both cases. Its low count restarts on every falling edge it observes, it waits without counting while the wire stays low after its own release, and it aborts its high count when another master pulls the wire low first.

The result on the bus is a low time set by the slowest participant and a high time set by the fastest. The raw SCL level passes through a synchronizer before edge detection. The block gives its data shifter one-cycle strobes for observed rising and falling edges. A run enable stops the generator cleanly at the end of a low period.

Top module: `scl_sync_gen`

## Requirements
- R1: During and after a synchronous reset, `scl_drive_low`, `rise_stb` and `fall_stb` are 0.
- R2: While `run_en` is 0 and the block is idle, `scl_drive_low` stays 0 whatever the SCL level.
- R3: With no other master present, every pulse of `scl_drive_low` lasts exactly `max(low_cnt,2)` cycles.
- R4: After releasing SCL, the block waits without counting until the synchronized level is high. Its high count starts only then. With no other master, the released interval is `max(high_cnt,2)+3` cycles: 2 synchronizer stages, 1 decision cycle, and the count.
- R5: When another master holds SCL low longer than the own low period, the bus low time follows that master. The bus high time that follows is still `max(high_cnt,2)+3` cycles.
- R6: A falling edge on SCL caused by another master while the block counts high aborts the count. `scl_drive_low` rises 3 cycles after the bus fall and lasts `max(low_cnt,2)` cycles.
- R7: If an external falling edge is recognised in the same cycle the high count expires, exactly one low period of `max(low_cnt,2)` cycles results.
- R8: `fall_stb` (or `rise_stb`) is a one-cycle pulse in the cycle after the third rising clock edge following a bus fall (or rise). The two strobes are never high together.
- R9: When `run_en` drops during a low period, that period completes at full length. SCL is then released and no further low pulse is driven. Dropping `run_en` during the high or wait phase returns the block to idle without a further pulse.
- R10: `low_cnt` or `high_cnt` values of 0 or 1 behave as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables clock generation |
| low_cnt | input | CNT_W | Low period in system cycles (minimum 2) |
| high_cnt | input | CNT_W | High period in system cycles (minimum 2) |
| scl_in | input | 1 | Raw level of the shared SCL wire |
| scl_drive_low | output | 1 | 1 = pull SCL low (open-drain enable) |
| rise_stb | output | 1 | One-cycle strobe on an observed SCL rise |
| fall_stb | output | 1 | One-cycle strobe on an observed SCL fall |

## Verification
Recognising a fall caused by another master and expiring the block's own high count can land on the same clock edge. Both ask for a new low period. The bench provokes this with a modelled second master that pulls the wire low exactly `high_cnt` cycles after the bus rises. It also sweeps the pull-down point earlier than that. In every case it checks that one low pulse of exactly the programmed length follows and that the bus high time equals the external master's choice. Stretching by a slower master and plain free-running operation are swept over all small low and high settings, including the clamped values.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_phase_e;

  localparam int unsigned MIN_PHASE = 2;
endpackage

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  output logic scl_lvl,
  output logic fall_det,
  output logic rise_stb,
  output logic fall_stb
);
  logic [STAGES-1:0] chain;
  logic              lvl_d;
  logic              rise_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      lvl_d <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], scl_raw};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign scl_lvl  = chain[STAGES-1];
  assign fall_det = lvl_d & ~scl_lvl;
  assign rise_det = ~lvl_d & scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= rise_det;
      fall_stb <= fall_det;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb)); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !fall_stb); // R8
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_sync_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_PHASE);

  scl_phase_e       state, state_n;
  logic             scl_lvl, fall_det, cnt_done, cnt_load;
  logic [CNT_W-1:0] eff_lo, eff_hi, load_val;

  scl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .scl_lvl(scl_lvl),
    .fall_det(fall_det), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  assign eff_lo = (low_cnt  < MIN_CNT) ? MIN_CNT : low_cnt;
  assign eff_hi = (high_cnt < MIN_CNT) ? MIN_CNT : high_cnt;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (run_en) begin
        if (fall_det)     state_n = ST_LOW;
        else if (scl_lvl) state_n = ST_HIGH;
      end
      ST_LOW:  if (cnt_done) state_n = run_en ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (!run_en)      state_n = ST_IDLE;
               else if (scl_lvl) state_n = ST_HIGH;
      ST_HIGH: if (!run_en)                  state_n = ST_IDLE;
               else if (fall_det || cnt_done) state_n = ST_LOW;
      default: state_n = ST_IDLE;
    endcase
  end

  assign cnt_load = (state_n != state) &&
                    ((state_n == ST_LOW) || (state_n == ST_HIGH));
  assign load_val = (state_n == ST_LOW) ? (eff_lo - 1'b1) : (eff_hi - 1'b1);

  scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(load_val), .done(cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      scl_drive_low <= 1'b0;
    end else begin
      state         <= state_n;
      scl_drive_low <= (state_n == ST_LOW);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !run_en) |=> !scl_drive_low); // R2
  AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !scl_drive_low); // R4
  AST_HIGH_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !scl_lvl) |=> (state != ST_HIGH)); // R4
  AST_FALL_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIGH && fall_det && run_en) |=> (state == ST_LOW && scl_drive_low)); // R6
  AST_STOP_AT_LOW_END: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW && cnt_done && !run_en) |=> (state == ST_IDLE && !scl_drive_low)); // R9
  AST_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_drive_low) |-> $past(scl_drive_low, 2)); // R10
endmodule

// File: tb/scl_sync_gen_tb_top.sv
module scl_sync_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst, run_en;
  logic [7:0] low_cnt, high_cnt;
  logic       scl_drive_low, rise_stb, fall_stb;
  logic       ext_drv;
  logic       bus;

  always #5 clk = ~clk;
  assign bus = ~(scl_drive_low | ext_drv);

  scl_sync_gen dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .scl_in(bus), .scl_drive_low(scl_drive_low),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  int checks = 0, errors = 0;
  int ext_mode = 0, ext_xl = 1, ext_k = 1;
  int ecnt, hi_run;
  logic e_prev;

  // second master model: mode 1 stretches low, mode 2 pulls low early
  always @(posedge clk) begin
    if (rst) begin
      ext_drv <= 1'b0; e_prev <= 1'b1; hi_run <= 0; ecnt <= 0;
    end else begin
      e_prev <= bus;
      hi_run <= bus ? hi_run + 1 : 0;
      if (ext_drv) begin
        if (ecnt == 0) ext_drv <= 1'b0; else ecnt <= ecnt - 1;
      end else if (ext_mode == 1 && e_prev && !bus) begin
        ext_drv <= 1'b1; ecnt <= ext_xl - 1;
      end else if (ext_mode == 2 && bus && hi_run == ext_k - 1) begin
        ext_drv <= 1'b1; ecnt <= ext_xl - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int bus_run, drv_run, bus_lo_len, bus_hi_len, drv_len, since_fall, since_rise, drv_starts;
  logic bus_p, drv_p, stb_en = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      bus_p = 1'b1; drv_p = 1'b0; bus_run = 0; drv_run = 0;
      since_fall = 100; since_rise = 100; drv_starts = 0;
    end else begin
      since_fall = (bus_p && !bus) ? 1 : since_fall + 1;
      since_rise = (!bus_p && bus) ? 1 : since_rise + 1;
      if (bus !== bus_p) begin
        if (bus_p) bus_hi_len = bus_run; else bus_lo_len = bus_run;
        bus_run = 1;
      end else bus_run++;
      if (scl_drive_low !== drv_p) begin
        if (drv_p) drv_len = drv_run; else drv_starts++;
        drv_run = 1;
      end else drv_run++;
      bus_p = bus; drv_p = scl_drive_low;
      if (stb_en && fall_stb) chk(since_fall == 4, "R8 fall strobe delay", since_fall, 4);
      if (stb_en && rise_stb) chk(since_rise == 4, "R8 rise strobe delay", since_rise, 4);
      if (stb_en && rise_stb && fall_stb) chk(0, "R8 strobes together", 1, 0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int eff(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int snap;
    logic prev;
    rst = 1'b1; run_en = 1'b0; low_cnt = 8'd3; high_cnt = 8'd3;
    wait_cyc(4);
    chk(scl_drive_low == 1'b0, "R1 drive after reset", scl_drive_low, 0);
    chk(rise_stb == 1'b0 && fall_stb == 1'b0, "R1 strobes after reset", rise_stb | fall_stb, 0);
    rst = 1'b0;
    wait_cyc(30);
    chk(drv_starts == 0, "R2 idle with run_en low", drv_starts, 0);
    chk(scl_drive_low == 1'b0, "R1 drive stays released", scl_drive_low, 0);

    run_en = 1'b1;
    wait_cyc(10);
    stb_en = 1'b1;
    // free running sweep, including clamped settings 0 and 1 (R10)
    for (int l = 0; l <= 5; l++) begin
      for (int h = 0; h <= 5; h++) begin
        low_cnt = 8'(l); high_cnt = 8'(h);
        wait_cyc(60);
        chk(drv_len == eff(l), (l < 2) ? "R10 clamped low" : "R3 own low length", drv_len, eff(l));
        chk(bus_hi_len == eff(h) + 3, (h < 2) ? "R10 clamped high" : "R4 released interval",
            bus_hi_len, eff(h) + 3);
      end
    end

    // slower master stretches the low phase
    for (int l = 2; l <= 4; l++) begin
      for (int h = 2; h <= 4; h++) begin
        low_cnt = 8'(l); high_cnt = 8'(h);
        ext_mode = 1; ext_xl = l + 4;
        wait_cyc(80);
        chk(bus_lo_len == ext_xl + 1, "R5 stretched bus low", bus_lo_len, ext_xl + 1);
        chk(bus_hi_len == h + 3, "R5 high after stretch", bus_hi_len, h + 3);
        chk(drv_len == l, "R5 own pulse unchanged", drv_len, l);
      end
    end

    // faster master pulls low early; k == h is the same-cycle case
    for (int l = 2; l <= 4; l++) begin
      for (int h = 2; h <= 4; h++) begin
        for (int k = 2; k <= h; k++) begin
          low_cnt = 8'(l); high_cnt = 8'(h);
          ext_mode = 2; ext_xl = 3; ext_k = k;
          wait_cyc(80);
          chk(bus_hi_len == k, (k == h) ? "R7 bus high on collision" : "R6 bus high follows early master",
              bus_hi_len, k);
          chk(drv_len == l, (k == h) ? "R7 single low on collision" : "R6 restarted low length",
              drv_len, l);
          chk(bus_lo_len == l + 3, "R6 drive starts 3 cycles after fall", bus_lo_len, l + 3);
        end
      end
    end

    // stop at end of low period
    ext_mode = 0; low_cnt = 8'd4; high_cnt = 8'd3;
    wait_cyc(60);
    prev = scl_drive_low;
    do begin
      @(negedge clk);
      if (scl_drive_low && !prev) break;
      prev = scl_drive_low;
    end while (1);
    run_en = 1'b0;
    wait_cyc(1);
    snap = drv_starts;
    wait_cyc(40);
    chk(drv_len == 4, "R9 last low completes", drv_len, 4);
    chk(drv_starts == snap, "R9 no pulse after stop", drv_starts - snap, 0);
    chk(scl_drive_low == 1'b0, "R9 released after stop", scl_drive_low, 0);

    // stop during the high phase
    run_en = 1'b1;
    do @(negedge clk); while (!(bus && !scl_drive_low && since_rise == 5));
    run_en = 1'b0;
    wait_cyc(1);
    snap = drv_starts;
    wait_cyc(40);
    chk(drv_starts == snap, "R9 stop during high", drv_starts - snap, 0);
    chk(bus == 1'b1, "R2 bus stays high when idle", bus, 1);

    finish_run();
  end
endmodule